// File: doc/BRIEF.md
# FP16 pair to E2M1 rounding quantizer

This block turns pairs of half-precision numbers into 4-bit E2M1 codes and packs each pair into one byte. The inputs are assumed to have already been divided by their group scale, so their useful range is about ±6. Each 32-bit input word carries two FP16 lanes. Each output byte carries the two matching nibbles.

Each nibble is formed as follows:
- Bit 3 is the sign.
- Bits 2:0 select one of eight magnitudes: 0, 0.5, 1, 1.5, 2, 3, 4 and 6.

Rounding to the nearest magnitude uses seven parallel comparisons of the FP16 magnitude against the midpoints between neighbouring values. There is no search loop and no lookup table.

Both sides are valid/ready streams. One output register sits between them, so a result appears one cycle after its word is accepted. A stalled consumer holds the result and stops new input. A sticky flag records that a NaN has been seen since reset.

Top module: `fp4_pair_quantizer`

## Requirements
- R1: After reset, `out_valid` is 0 and `nan_seen` is 0.
- R2: A non-NaN lane maps to code bits 2:0 equal to the index of the nearest value in the list 0, 0.5, 1, 1.5, 2, 3, 4, 6. Index 0 is 0 and index 7 is 6. The midpoints between neighbours are 0.25, 0.75, 1.25, 1.75, 2.5, 3.5 and 5.
- R3: A magnitude exactly on a midpoint rounds to the neighbour whose index is even, so code bit 0 is 0. For example, 0.25 gives 0, 0.75 gives 2, 2.5 gives 4 and 5 gives 6.
- R4: A magnitude above 6, including the largest finite value and infinity, gives code bits 2:0 = 7. The sign is kept in bit 3.
- R5: A NaN lane gives the nibble 0x7, whatever its sign. Accepting a word with a NaN in any lane sets `nan_seen` on the next clock edge. The flag then stays at 1 until reset. Words without NaN never set it.
- R6: For non-NaN lanes, nibble bit 3 equals FP16 bit 15, including results that round to zero. For example, -0 gives 0x8.
- R7: Input bits 15:0 (the even lane) produce `out_byte[3:0]`. Input bits 31:16 (the odd lane) produce `out_byte[7:4]`.
- R8: A word accepted at a clock edge (`in_valid` and `in_ready` both high) is on `out_byte` with `out_valid` = 1 after that edge.
- R9: While `out_valid` is 1 and `out_ready` is 0, the following hold:
  - `in_ready` is 0.
  - `out_valid` stays 1.
  - `out_byte` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 32 | Two FP16 lanes: bits 15:0 even, 31:16 odd |
| out_valid | output | 1 | Output byte holds a result |
| out_ready | input | 1 | Consumer takes the byte this cycle |
| out_byte | output | 8 | Packed E2M1 pair: even lane low nibble |
| nan_seen | output | 1 | Sticky: a NaN lane was accepted since reset |

## Verification
The bench places a value exactly on every midpoint. A design that rounds ties up, or that uses strict comparisons everywhere, would return odd codes there. It also probes one ulp either side of several midpoints, which catches a comparator set against the wrong constant. It drives infinity, the largest finite value and NaN of both signs to separate saturation from NaN handling. It drives negative zero and small negatives, where a design that drops the sign of a zero result would output 0x0 instead of 0x8. It sends asymmetric pairs to expose swapped nibbles, and it stalls the consumer to show that a held byte is overwritten neither by new input nor by a lost handshake.

// File: rtl/fp4_pair_quantizer.sv
module fp4_pair_quantizer #(
  parameter int LANES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [16*LANES-1:0]  in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [4*LANES-1:0]   out_byte,
  output logic                 nan_seen
);

  localparam logic [14:0] EXP_ALL = 15'h7C00;

  function automatic logic is_nan(input logic [15:0] h);
    return (h[14:10] == 5'h1F) && (h[9:0] != 10'h0);
  endfunction

  function automatic logic [3:0] quantize(input logic [15:0] h);
    logic [14:0] m;
    logic [2:0]  idx;
    m = h[14:0];
    if (m > EXP_ALL) return 4'h7;
    idx = {2'b0, m >  15'h3400}
        + {2'b0, m >= 15'h3A00}
        + {2'b0, m >  15'h3D00}
        + {2'b0, m >= 15'h3F00}
        + {2'b0, m >  15'h4100}
        + {2'b0, m >= 15'h4300}
        + {2'b0, m >  15'h4500};
    return {h[15], idx};
  endfunction

  logic [4*LANES-1:0] nib;
  logic [LANES-1:0]   lane_nan;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign nib[4*i +: 4]  = quantize(in_data[16*i +: 16]);
    assign lane_nan[i]    = is_nan(in_data[16*i +: 16]);
  end

  wire take = in_valid && in_ready;
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      nan_seen  <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_byte  <= nib;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (take && |lane_nan) nan_seen <= 1'b1;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nan_seen |=> nan_seen);

  p_nan_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_data[14:0] > EXP_ALL |=> out_byte[3:0] == 4'h7 && nan_seen);

  p_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_data[14:0] <= EXP_ALL |=> out_byte[3] == $past(in_data[15]));

  p_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_data[14:0] > 15'h4600 |=> out_byte[2:0] == 3'h7);

endmodule

// File: tb/sim_fp4_pair_quantizer.sv
module sim_fp4_pair_quantizer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [7:0] out_byte;
  logic nan_seen;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp4_pair_quantizer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .nan_seen(nan_seen)
  );

  // {odd lane, even lane, expected byte}
  localparam int NV = 19;
  localparam logic [39:0] VEC [NV] = '{
    {32'h3400_0000, 8'h00},  // R3 tie 0.25 -> 0
    {32'h3800_3500, 8'h11},  // R2
    {32'h3980_3A00, 8'h12},  // R3 tie 0.75 -> 2
    {32'h3D00_3C00, 8'h22},  // R3 tie 1.25 -> 2
    {32'h3E00_3D40, 8'h33},  // R2
    {32'h4000_3F00, 8'h44},  // R3 tie 1.75 -> 4
    {32'h4180_4100, 8'h54},  // R3 tie 2.5 -> 4
    {32'h4300_4200, 8'h65},  // R3 tie 3.5 -> 6
    {32'h4500_4400, 8'h66},  // R3 tie 5 -> 6
    {32'h4600_4580, 8'h77},  // R2
    {32'h7C00_5640, 8'h77},  // R4 inf, 100
    {32'h0001_7BFF, 8'h07},  // R4 max finite, subnormal
    {32'h3401_33FF, 8'h10},  // R2 ulp around 0.25
    {32'h39FF_3A01, 8'h12},  // R2 ulp around 0.75
    {32'h8000_B800, 8'h89},  // R6 -0, -0.5
    {32'hFC00_AE66, 8'hF8},  // R6 R4 -inf, -0.1
    {32'hC300_C600, 8'hEF},  // R6 -3.5 tie, -6
    {32'h4600_0000, 8'h70},  // R7 odd lane high nibble
    {32'h0000_4600, 8'h07}   // R7 even lane low nibble
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_data  = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid", {7'b0, out_valid}, 8'h00);
    check("R1 nan_seen", {7'b0, nan_seen}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][39:8]);
      check("R8 out_valid", {7'b0, out_valid}, 8'h01);
      check($sformatf("R2 vector %0d", i), out_byte, VEC[i][7:0]);
    end
    check("R5 no NaN yet", {7'b0, nan_seen}, 8'h00);

    send(32'hFE00_3C00);
    check("R5 -NaN high", out_byte, 8'h72);
    check("R5 flag set", {7'b0, nan_seen}, 8'h01);
    send(32'h3800_7C01);
    check("R5 NaN low", out_byte, 8'h17);
    send(32'h3C00_3C00);
    check("R5 flag sticky", {7'b0, nan_seen}, 8'h01);
    check("R2 after NaN", out_byte, 8'h22);

    @(negedge clk);
    out_ready = 1'b0;
    in_data   = 32'h4400_3800;
    in_valid  = 1'b1;
    @(negedge clk);
    check("R8 stalled first", out_byte, 8'h61);
    in_data = 32'hB800_4600;
    check("R9 in_ready low", {7'b0, in_ready}, 8'h00);
    @(negedge clk);
    @(negedge clk);
    check("R9 held byte", out_byte, 8'h61);
    check("R9 held valid", {7'b0, out_valid}, 8'h01);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 next after release", out_byte, 8'h97);
    @(negedge clk);
    check("R8 drained", {7'b0, out_valid}, 8'h00);

    rst_n = 1'b0;
    @(negedge clk);
    check("R1 flag cleared", {7'b0, nan_seen}, 8'h00);
    check("R1 valid cleared", {7'b0, out_valid}, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule